// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped First-Level Cache

This block is a small fully associative store of whole cache lines that sits on the refill path of a direct-mapped first-level cache. The first-level cache consults it only after its own lookup misses. In victim mode, the line that the first-level cache throws out on a miss is written here. The fetched line is not. A later conflict miss on that thrown-out line is then served from this buffer one cycle after the lookup, and no next-level access is needed. In victim mode a hit is a swap. The hit line leaves the buffer and goes back to the first-level cache, and the line that the first-level cache gives up in exchange takes over the slot that was freed. A build-time parameter instead selects miss-cache mode. In that mode the first-level cache copies each line returned by the next level into the buffer as well, and hits leave the entry in place.

Each entry holds a valid flag, a dirty flag, the full line address and the line data. Since the store has no index bits, matching compares the entire line address. Replacement follows true least-recently-used order. When a replacement displaces a dirty line, that line is offered on a write-back port, and the entry is overwritten only after the next level accepts it. The control is a two-state machine. `ST_IDLE` serves lookups and inserts. `ST_WB_WAIT` holds a pending insert while a displaced dirty line waits for acceptance. The transition `ST_IDLE -> ST_WB_WAIT` is taken when an accepted insert would displace a valid dirty entry. The transition `ST_WB_WAIT -> ST_IDLE` is taken in the cycle `wb_ready` is high, and the pending line is written in that same cycle.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses; `lk_ready` and `ins_ready` are 1 and `wb_valid` is 0.
- R2: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` high) gives `rsp_valid` high for the following cycle. `rsp_hit` is 1 only when a valid entry holds exactly the full `lk_addr`, and then `rsp_data` and `rsp_dirty` are that entry's data and dirty flag.
- R3: An insert is placed by this priority. First, an entry already holding `ins_addr` is updated in place: its data is replaced and its dirty flag becomes old OR new. Second, the slot freed by the last victim-mode hit. Third, the lowest-numbered invalid entry. Last, the least recently used entry. No address is ever held twice.
- R4: Every insert, and every lookup hit in miss-cache mode, makes its entry the most recently used. A replacement always takes the least recently used valid entry.
- R5: In victim mode a lookup hit removes the entry, so a repeated lookup of that address misses. The next insert fills the freed slot without displacing any other entry.
- R6: An insert that displaces a valid dirty entry moves to `ST_WB_WAIT`. In that state `wb_valid` is 1 with the displaced line's address and data, held stable until `wb_ready`, and `lk_ready` and `ins_ready` are 0. The new line is written only in the accepting cycle, and the machine then returns to `ST_IDLE`.
- R7: Displacing a clean or invalid entry issues no write-back, and the insert completes in one cycle.
- R8: In miss-cache mode `ins_dirty` is ignored. Entries are stored clean, `rsp_dirty` is always 0, `wb_valid` never rises, and a hit leaves the entry in place.
- R9: When a lookup and an insert arrive in the same cycle, the lookup goes first. `ins_ready` is 0 while `lk_valid` is 1, so the lookup is answered against the state before the insert, and the insert is accepted in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request after a first-level miss |
| lk_ready | output | 1 | Lookup can be taken this cycle |
| lk_addr | input | ADDR_W | Line address to look up |
| rsp_valid | output | 1 | Lookup result is valid this cycle |
| rsp_hit | output | 1 | Looked-up line was present |
| rsp_dirty | output | 1 | Dirty flag of the hit line |
| rsp_data | output | DATA_W | Data of the hit line |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_addr | input | ADDR_W | Line address to insert |
| ins_data | input | DATA_W | Line data to insert |
| ins_dirty | input | 1 | Inserted line is modified |
| wb_valid | output | 1 | Displaced dirty line offered to the next level |
| wb_ready | input | 1 | Next level accepts the write-back |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
The hardest state to reach from the ports is a dirty line sitting at the least-recently-used position of a full buffer while a victim-mode swap is also in progress. Reaching it needs an ordered mix of dirty and clean inserts, hits that free slots, and refills of those slots. The vector table walks one such sequence, so that two different dirty lines age to the oldest position, one of them after an in-place update. A directed test then holds `wb_ready` low across several cycles to expose the stall. A further test drives a lookup and an insert for the same address in one cycle to show that the lookup comes first.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_WB_WAIT = 1'b1
    } vc_state_e;

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 26,
    parameter int IDX_W       = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_ENTRIES-1:0]               valid_i,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]   addr_i,
    input  logic [ADDR_W-1:0]                    probe_i,
    output logic                                 hit_o,
    output logic [IDX_W-1:0]                     idx_o
);

    logic [NUM_ENTRIES-1:0] match;

    // full line address compare: no index bits exist
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (addr_i[g] == probe_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

    // R3: placement never lets an address sit in two entries
    assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] valid_i,
    input  logic                   touch_en_i,
    input  logic [IDX_W-1:0]       touch_idx_i,
    output logic [IDX_W-1:0]       repl_idx_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0]       age_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] is_old;

    // ages form a permutation of 0..N-1; 0 is most recent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en_i) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx_i)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_old
        assign is_old[g] = (age_q[g] == OLDEST);
    end

    always_comb begin
        repl_idx_o = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (is_old[i]) repl_idx_o = IDX_W'(i);
        end
        // an invalid entry, lowest index, wins over the oldest one
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) repl_idx_o = IDX_W'(i);
        end
    end

    // R4: exactly one entry holds the least-recent position
    assert_single_lru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1);

endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import vc_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 26,
    parameter int DATA_W      = 32,
    parameter bit VICTIM_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              ins_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    // entry storage
    logic [NUM_ENTRIES-1:0]             ent_valid;
    logic [NUM_ENTRIES-1:0]             ent_dirty;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [NUM_ENTRIES-1:0][DATA_W-1:0] ent_data;

    vc_state_e state_q, state_nx;

    // freed slot after a victim-mode hit, pending insert during write-back
    logic              hold_vld_q;
    logic [IDX_W-1:0]  hold_idx_q;
    logic [IDX_W-1:0]  vic_idx_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic              pend_dirty_q;

    logic              lk_hit, ins_hit;
    logic [IDX_W-1:0]  lk_idx, ins_idx, repl_idx;
    logic              lk_fire, ins_fire, needs_wb, ins_dirty_eff;
    logic [IDX_W-1:0]  slot;
    logic              w_en, kill_en, touch_en;
    logic [IDX_W-1:0]  w_idx, touch_idx;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              w_dirty;

    vc_tag_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .valid_i(ent_valid), .addr_i(ent_addr),
        .probe_i(lk_addr), .hit_o(lk_hit), .idx_o(lk_idx));

    vc_tag_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ins_match (
        .clk(clk), .rst_n(rst_n), .valid_i(ent_valid), .addr_i(ent_addr),
        .probe_i(ins_addr), .hit_o(ins_hit), .idx_o(ins_idx));

    vc_lru #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .valid_i(ent_valid), .touch_en_i(touch_en),
        .touch_idx_i(touch_idx), .repl_idx_o(repl_idx));

    // insert placement priority: same address, freed slot, invalid, LRU
    always_comb begin
        ins_dirty_eff = VICTIM_MODE ? ins_dirty : 1'b0;
        if (ins_hit)         slot = ins_idx;
        else if (hold_vld_q) slot = hold_idx_q;
        else                 slot = repl_idx;
        needs_wb = !ins_hit && !hold_vld_q && ent_valid[slot] && ent_dirty[slot];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (ins_fire && needs_wb) state_nx = ST_WB_WAIT;
            ST_WB_WAIT: if (wb_ready)             state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // outputs and write-port decode
    always_comb begin
        lk_ready  = 1'b0;
        ins_ready = 1'b0;
        wb_valid  = 1'b0;
        w_en      = 1'b0;
        w_idx     = slot;
        w_addr    = ins_addr;
        w_data    = ins_data;
        w_dirty   = ins_hit ? (ent_dirty[ins_idx] | ins_dirty_eff) : ins_dirty_eff;
        unique case (state_q)
            ST_IDLE: begin
                lk_ready  = 1'b1;
                ins_ready = !lk_valid;
                w_en      = ins_valid && !lk_valid && !needs_wb;
            end
            ST_WB_WAIT: begin
                wb_valid = 1'b1;
                w_en     = wb_ready;
                w_idx    = vic_idx_q;
                w_addr   = pend_addr_q;
                w_data   = pend_data_q;
                w_dirty  = pend_dirty_q;
            end
            default: ;
        endcase
        lk_fire   = lk_valid && lk_ready;
        ins_fire  = ins_valid && ins_ready;
        kill_en   = VICTIM_MODE && lk_fire && lk_hit;
        touch_en  = w_en || (!VICTIM_MODE && lk_fire && lk_hit);
        touch_idx = w_en ? w_idx : lk_idx;
        wb_addr   = ent_addr[vic_idx_q];
        wb_data   = ent_data[vic_idx_q];
    end

    // entry storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_dirty <= '0;
            ent_addr  <= '0;
            ent_data  <= '0;
        end else begin
            if (kill_en) ent_valid[lk_idx] <= 1'b0;
            if (w_en) begin
                ent_valid[w_idx] <= 1'b1;
                ent_dirty[w_idx] <= w_dirty;
                ent_addr[w_idx]  <= w_addr;
                ent_data[w_idx]  <= w_data;
            end
        end
    end

    // control registers and lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld_q   <= 1'b0;
            hold_idx_q   <= '0;
            vic_idx_q    <= '0;
            pend_addr_q  <= '0;
            pend_data_q  <= '0;
            pend_dirty_q <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_dirty    <= 1'b0;
            rsp_data     <= '0;
        end else begin
            if (ins_fire) begin
                hold_vld_q <= 1'b0;
            end else if (kill_en) begin
                hold_vld_q <= 1'b1;
                hold_idx_q <= lk_idx;
            end
            if (ins_fire && needs_wb) begin
                vic_idx_q    <= slot;
                pend_addr_q  <= ins_addr;
                pend_data_q  <= ins_data;
                pend_dirty_q <= ins_dirty_eff;
            end
            rsp_valid <= lk_fire;
            rsp_hit   <= lk_fire && lk_hit;
            rsp_dirty <= lk_fire && lk_hit && ent_dirty[lk_idx];
            rsp_data  <= ent_data[lk_idx];
        end
    end

    // R2: a hit is only reported inside a response cycle
    assert_hit_in_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R6: an unaccepted write-back keeps its line steady
    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

    // R6: nothing is taken while a write-back is outstanding
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !ins_ready && !lk_ready);

    // R9: a lookup in the same cycle holds the insert back
    assert_lookup_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> !ins_ready);

    if (!VICTIM_MODE) begin : g_mc_chk
        // R8: miss-cache entries are clean and never written back
        assert_mc_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !wb_valid && !(rsp_valid && rsp_dirty));
    end

endmodule

// File: tb/victim_cache_bench.sv
`timescale 1ns/1ps
module victim_cache_bench;

    localparam int AW = 26;
    localparam int DW = 32;
    localparam int NV = 16;

    typedef struct packed {
        logic          is_lk;
        logic [3:0]    req;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          dirty;
        logic          exp_hit;
        logic          exp_dirty;
        logic [DW-1:0] exp_data;
        logic          exp_wb;
        logic [AW-1:0] exp_wb_addr;
        logic [DW-1:0] exp_wb_data;
    } vec_t;

    // victim-mode walk over a 4-entry buffer
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1, 26'h10, 32'h0,    1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R1 empty miss
        '{1'b0, 4'd3, 26'h10, 32'h1000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R3 invalid slot
        '{1'b0, 4'd3, 26'h11, 32'h1100, 1'b1, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},
        '{1'b0, 4'd3, 26'h12, 32'h1200, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},
        '{1'b0, 4'd3, 26'h13, 32'h1300, 1'b1, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},
        '{1'b1, 4'd2, 26'h10, 32'h0,    1'b0, 1'b1, 1'b0, 32'h1000, 1'b0, 26'h0,  32'h0},    // R2 hit
        '{1'b0, 4'd5, 26'h20, 32'h2000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R5 swap-in
        '{1'b1, 4'd5, 26'h10, 32'h0,    1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R5 removed
        '{1'b0, 4'd6, 26'h21, 32'h2100, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 26'h11, 32'h1100}, // R6 dirty LRU out
        '{1'b0, 4'd7, 26'h22, 32'h2200, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R7 clean LRU out
        '{1'b1, 4'd4, 26'h11, 32'h0,    1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R4
        '{1'b1, 4'd2, 26'h13, 32'h0,    1'b0, 1'b1, 1'b1, 32'h1300, 1'b0, 26'h0,  32'h0},    // R2 dirty hit
        '{1'b0, 4'd5, 26'h30, 32'h3000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R5 freed slot
        '{1'b0, 4'd3, 26'h21, 32'h2101, 1'b1, 1'b0, 1'b0, 32'h0,    1'b0, 26'h0,  32'h0},    // R3 in place
        '{1'b0, 4'd4, 26'h40, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 26'h20, 32'h2000}, // R4 order
        '{1'b1, 4'd3, 26'h21, 32'h0,    1'b0, 1'b1, 1'b1, 32'h2101, 1'b0, 26'h0,  32'h0}     // R3 merged
    };

    logic clk = 1'b0;
    logic rst_n;
    logic lk_valid, ins_valid, ins_dirty, wb_ready;
    logic [AW-1:0] lk_addr, ins_addr;
    logic [DW-1:0] ins_data;

    logic lk_ready_v, rsp_valid_v, rsp_hit_v, rsp_dirty_v, ins_ready_v, wb_valid_v;
    logic [DW-1:0] rsp_data_v, wb_data_v;
    logic [AW-1:0] wb_addr_v;
    logic lk_ready_m, rsp_valid_m, rsp_hit_m, rsp_dirty_m, ins_ready_m, wb_valid_m;
    logic [DW-1:0] rsp_data_m, wb_data_m;
    logic [AW-1:0] wb_addr_m;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    victim_cache #(.NUM_ENTRIES(4), .ADDR_W(AW), .DATA_W(DW), .VICTIM_MODE(1'b1)) u_victim_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready_v), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid_v), .rsp_hit(rsp_hit_v), .rsp_dirty(rsp_dirty_v), .rsp_data(rsp_data_v),
        .ins_valid(ins_valid), .ins_ready(ins_ready_v), .ins_addr(ins_addr),
        .ins_data(ins_data), .ins_dirty(ins_dirty),
        .wb_valid(wb_valid_v), .wb_ready(wb_ready), .wb_addr(wb_addr_v), .wb_data(wb_data_v));

    victim_cache #(.NUM_ENTRIES(4), .ADDR_W(AW), .DATA_W(DW), .VICTIM_MODE(1'b0)) u_victim_cache_mc (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready_m), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid_m), .rsp_hit(rsp_hit_m), .rsp_dirty(rsp_dirty_m), .rsp_data(rsp_data_m),
        .ins_valid(ins_valid), .ins_ready(ins_ready_m), .ins_addr(ins_addr),
        .ins_data(ins_data), .ins_dirty(ins_dirty),
        .wb_valid(wb_valid_m), .wb_ready(wb_ready), .wb_addr(wb_addr_m), .wb_data(wb_data_m));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0; ins_valid = 1'b0; ins_dirty = 1'b0;
        lk_addr = '0; ins_addr = '0; ins_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives one lookup at a negedge; response is sampled one negedge later
    task automatic do_lookup(input logic [AW-1:0] a);
        @(negedge clk);
        while (!(lk_ready_v && lk_ready_m)) @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_insert(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dt);
        @(negedge clk);
        while (!(ins_ready_v && ins_ready_m)) @(negedge clk);
        ins_valid = 1'b1;
        ins_addr  = a;
        ins_data  = d;
        ins_dirty = dt;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wb_ready = 1'b1;
        do_reset();
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 lk_ready", lk_ready_v, 1);
        chk("R1 ins_ready", ins_ready_v, 1);
        chk("R1 wb_valid", wb_valid_v, 0);
        chk("R1 rsp_valid", rsp_valid_v, 0);

        // vector table walk, victim mode
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_lk) begin
                do_lookup(VECS[i].addr);
                chk($sformatf("R%0d row%0d rsp_valid", VECS[i].req, i), rsp_valid_v, 1);
                chk($sformatf("R%0d row%0d hit", VECS[i].req, i), rsp_hit_v, VECS[i].exp_hit);
                if (VECS[i].exp_hit) begin
                    chk($sformatf("R%0d row%0d data", VECS[i].req, i), rsp_data_v, VECS[i].exp_data);
                    chk($sformatf("R%0d row%0d dirty", VECS[i].req, i), rsp_dirty_v, VECS[i].exp_dirty);
                end
            end else begin
                do_insert(VECS[i].addr, VECS[i].data, VECS[i].dirty);
                chk($sformatf("R%0d row%0d wb_valid", VECS[i].req, i), wb_valid_v, VECS[i].exp_wb);
                if (VECS[i].exp_wb) begin
                    chk($sformatf("R%0d row%0d wb_addr", VECS[i].req, i), wb_addr_v, VECS[i].exp_wb_addr);
                    chk($sformatf("R%0d row%0d wb_data", VECS[i].req, i), wb_data_v, VECS[i].exp_wb_data);
                end
            end
        end
        // R2 response lasts one cycle
        @(negedge clk);
        chk("R2 rsp_valid drops", rsp_valid_v, 0);

        // R6 write-back stall with wb_ready held low
        do_reset();
        do_insert(26'h50, 32'h5000, 1'b1);
        do_insert(26'h51, 32'h5100, 1'b0);
        do_insert(26'h52, 32'h5200, 1'b0);
        do_insert(26'h53, 32'h5300, 1'b0);
        wb_ready = 1'b0;
        do_insert(26'h54, 32'h5400, 1'b0);
        for (int k = 0; k < 3; k++) begin
            chk("R6 wb_valid held", wb_valid_v, 1);
            chk("R6 wb_addr", wb_addr_v, 26'h50);
            chk("R6 wb_data", wb_data_v, 32'h5000);
            chk("R6 ins_ready low", ins_ready_v, 0);
            chk("R6 lk_ready low", lk_ready_v, 0);
            @(negedge clk);
        end
        wb_ready = 1'b1;
        @(negedge clk);
        chk("R6 wb done", wb_valid_v, 0);
        chk("R6 idle again", ins_ready_v, 1);
        do_lookup(26'h54);
        chk("R6 new line present", rsp_hit_v, 1);
        chk("R6 new line data", rsp_data_v, 32'h5400);
        do_lookup(26'h50);
        chk("R6 old line gone", rsp_hit_v, 0);
        do_lookup(26'h51);
        chk("R7 neighbour kept", rsp_hit_v, 1);

        // R9 lookup and insert in the same cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 26'h80;
        ins_valid = 1'b1; ins_addr = 26'h80; ins_data = 32'h8000; ins_dirty = 1'b0;
        #1;
        chk("R9 insert held", ins_ready_v, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R9 lookup answered", rsp_valid_v, 1);
        chk("R9 lookup saw old state", rsp_hit_v, 0);
        #1;
        chk("R9 insert now ready", ins_ready_v, 1);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R7 no wb on insert", wb_valid_v, 0);
        do_lookup(26'h80);
        chk("R9 insert landed", rsp_hit_v, 1);
        chk("R9 insert data", rsp_data_v, 32'h8000);

        // R8 / R4 miss-cache mode instance
        do_reset();
        for (int k = 1; k <= 4; k++) begin
            do_insert(AW'(k), 32'hA0 + DW'(k), 1'b1);
            chk("R8 no wb in miss mode", wb_valid_m, 0);
        end
        do_lookup(26'h1);
        chk("R8 hit", rsp_hit_m, 1);
        chk("R8 stored clean", rsp_dirty_m, 0);
        chk("R8 data", rsp_data_m, 32'hA1);
        do_lookup(26'h1);
        chk("R8 hit keeps entry", rsp_hit_m, 1);
        do_insert(26'h5, 32'hA5, 1'b1);
        chk("R8 eviction without wb", wb_valid_m, 0);
        do_lookup(26'h2);
        chk("R4 LRU entry replaced", rsp_hit_m, 0);
        do_lookup(26'h1);
        chk("R4 touched entry kept", rsp_hit_m, 1);
        do_lookup(26'h5);
        chk("R4 new entry present", rsp_hit_m, 1);

        // R1 reset clears contents
        do_reset();
        do_lookup(26'h5);
        chk("R1 miss after reset (miss mode)", rsp_hit_m, 0);
        do_lookup(26'h1);
        chk("R1 miss after reset (victim mode)", rsp_hit_v, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule